// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

The controller gathers up to 32 synchronous interrupt request lines and hands them to a processor through eight word registers on a single-cycle register bus. Each request line is fixed at elaboration as edge-sensitive or level-sensitive by a mask parameter. The controller keeps a status word of captured requests and an enable word. From these it forms the pending word, a vector holding the lowest pending index, and a single interrupt output to the processor.

Software reads the vector to find the source it should service. It then clears that source with a write-one acknowledge, and it edits the enable word with write-one set and clear operations. A two-bit control register gates the processor output and arms hardware capture. Arming capture also locks direct writes to the status word. While capture is disarmed, software can load the status word directly and so raise interrupts itself.

The register bus carries no stream and has no back-pressure. A write strobe takes effect at the clock edge where it is sampled. A read strobe returns data combinationally in the same cycle. No access ever waits.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and control read 0, pending reads 0, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: The register is selected by byte address bits [4:2], and bits [1:0] are ignored. The word offsets are: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 control. Offsets 3, 4 and 5 read as 0.
- R3: A write to control keeps only data bits [1:0]. Bit 0 gates the output. Bit 1 arms capture and locks status writes.
- R4: Pending always reads status AND enable. Writes to the pending offset and the vector offset change nothing.
- R5: The vector reads the index of the lowest set pending bit, zero-extended, or 0xFFFFFFFF when pending is zero.
- R6: `irq_out` is high exactly when control bit 0 is 1 and pending is nonzero.
- R7: A write to acknowledge clears each status bit whose data bit is 1 and leaves the other status bits unchanged.
- R8: A write to set-enable ORs the data into enable.
- R9: A write to clear-enable clears each enable bit whose data bit is 1.
- R10: While control bit 1 is 1, a level-sensitive input (mask bit 0) sets its status bit on every clock edge at which it is high. This holds even at an edge where the same bit is acknowledged.
- R11: While control bit 1 is 1, an edge-sensitive input (mask bit 1) sets its status bit only at a clock edge where it is high and was low at the previous edge. Holding it high does not set the bit again after an acknowledge.
- R12: A write to status replaces the status word when control bit 1 is 0, and has no effect when control bit 1 is 1.
- R13: While control bit 1 is 0, the request inputs do not change status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N | Interrupt request lines |
| bus_wr | input | 1 | Write strobe, acts at the sampling edge |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read is strobed |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is a collision at one clock edge between an acknowledge and a request line that is still asserted. A level-sensitive source must survive it, and an edge-sensitive source must not be captured again. The stimulus holds a level line high and an edge line high across an acknowledge write, reads status right after, and then drops and re-raises the edge line to show that a fresh edge is still seen. The status lock is reached by arming capture first and then attempting an all-ones status write.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W  = 32;
  localparam int REG_CNT = 8;
  localparam int ADDR_W  = $clog2(REG_CNT) + 2;

  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_PEND  = 3'd1,
    SEL_EN    = 3'd2,
    SEL_ACK   = 3'd3,
    SEL_SETEN = 3'd4,
    SEL_CLREN = 3'd5,
    SEL_VEC   = 3'd6,
    SEL_CTRL  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int          N         = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] hits
);
  for (genvar b = 0; b < N; b++) begin : g_line
    if (EDGE_MASK[b]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= irq_in[b];
      end
      assign hits[b] = arm & irq_in[b] & ~prev_q;
    end else begin : g_level
      assign hits[b] = arm & irq_in[b];
    end
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  logic [N-1:0] wdata,
  input  logic [1:0]   wctrl,
  input  logic [N-1:0] hits,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] en_q,
  output logic [1:0]   ctrl_q
);
  logic [N-1:0] stat_d, en_d;
  logic [1:0]   ctrl_d;

  always_comb begin
    stat_d = stat_q;
    en_d   = en_q;
    ctrl_d = ctrl_q;
    if (wr) begin
      unique case (sel)
        SEL_STAT:  if (!ctrl_q[1]) stat_d = wdata;
        SEL_ACK:   stat_d = stat_q & ~wdata;
        SEL_EN:    en_d   = wdata;
        SEL_SETEN: en_d   = en_q | wdata;
        SEL_CLREN: en_d   = en_q & ~wdata;
        SEL_CTRL:  ctrl_d = wctrl;
        default:   ;
      endcase
    end
    // capture lands after any software update of the same edge
    stat_d = stat_d | hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      ctrl_q <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int          N         = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  reg_sel_e         sel;
  logic [N-1:0]     stat_q, en_q, pend, hits;
  logic [1:0]       ctrl_q;
  logic             found;
  logic [IDX_W-1:0] idx;
  logic             unused_addr_lsb;

  assign sel             = reg_sel_e'(bus_addr[ADDR_W-1:2]);
  assign unused_addr_lsb = ^bus_addr[1:0];

  irq_sense #(.N(N), .EDGE_MASK(EDGE_MASK)) u_sense (
    .clk(clk), .rst_n(rst_n), .arm(ctrl_q[1]), .irq_in(irq_in), .hits(hits)
  );

  irq_state_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel),
    .wdata(bus_wdata[N-1:0]), .wctrl(bus_wdata[1:0]), .hits(hits),
    .stat_q(stat_q), .en_q(en_q), .ctrl_q(ctrl_q)
  );

  assign pend = stat_q & en_q;

  irq_first_set #(.N(N)) u_first (.pend(pend), .found(found), .idx(idx));

  assign irq_out = ctrl_q[0] & (|pend);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_STAT: bus_rdata[N-1:0] = stat_q;
        SEL_PEND: bus_rdata[N-1:0] = pend;
        SEL_EN:   bus_rdata[N-1:0] = en_q;
        SEL_VEC:  bus_rdata = found ? DATA_W'(idx) : '1;
        SEL_CTRL: bus_rdata[1:0] = ctrl_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int          N         = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      irq_in,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_out,
  input logic [N-1:0]      stat,
  input logic [N-1:0]      en,
  input logic [1:0]        ctrl
);
  localparam logic [N-1:0] LEVEL = ~EDGE_MASK[N-1:0];
  logic [2:0] sel;
  assign sel = bus_addr[ADDR_W-1:2];

  // R6: output gated by control bit 0
  assert_out_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> !irq_out);

  // R7: acknowledged bits are gone unless capture is armed
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_ACK && !ctrl[1]) |=> ((stat & $past(bus_wdata[N-1:0])) == '0));

  // R8: set-enable adds the written ones and drops nothing
  assert_seten_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_SETEN) |=>
      (((en & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])) && (($past(en) & ~en) == '0)));

  // R9: clear-enable removes the written ones
  assert_clren_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CLREN) |=> ((en & $past(bus_wdata[N-1:0])) == '0));

  // R10: armed level lines always land in status
  assert_level_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1] |=> ((stat & $past(irq_in & LEVEL)) == $past(irq_in & LEVEL)));

  // R12: locked status write loses no bit
  assert_stat_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_STAT && ctrl[1]) |=> (($past(stat) & ~stat) == '0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(N), .EDGE_MASK(EDGE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
  .stat(stat_q), .en(en_q), .ctrl(ctrl_q)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  localparam int N = 32;
  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                         A_SETEN = 5'h10, A_CLREN = 5'h14, A_VEC = 5'h18, A_CTRL = 5'h1C;

  typedef struct { logic [31:0] exp; string tag; bit is_irq; } item_t;
  item_t q[$];

  logic        clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic        bus_wr = 0, bus_rd = 0, probe = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_out;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.N(N), .EDGE_MASK(32'hFFFF_0000)) i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // monitor: pops the expected item and compares
  always @(negedge clk) begin
    if (bus_rd || probe) begin
      item_t it;
      logic [31:0] act;
      n_checks++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: act=%h exp=none", bus_rdata);
      end else begin
        it  = q.pop_front();
        act = it.is_irq ? {31'd0, irq_out} : bus_rdata;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    q.push_back('{exp: e, tag: tag, is_irq: 0});
    @(posedge clk); #1; bus_rd = 1; bus_addr = a;
    @(posedge clk); #1; bus_rd = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    q.push_back('{exp: {31'd0, e}, tag: tag, is_irq: 1});
    @(posedge clk); #1; probe = 1;
    @(posedge clk); #1; probe = 0;
  endtask

  task automatic drive_irq(input logic [N-1:0] v, input int hold);
    @(posedge clk); #1; irq_in = v;
    repeat (hold) @(posedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(A_STAT, 32'h0, "R1 status");
    rd(A_PEND, 32'h0, "R1 pending");
    rd(A_EN,   32'h0, "R1 enable");
    rd(A_CTRL, 32'h0, "R1 control");
    rd(A_VEC,  32'hFFFF_FFFF, "R1 vector");
    chk_irq(1'b0, "R1 irq_out");
    // R3 control width
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, 32'h3, "R3 control keeps two bits");
    wr(A_CTRL, 32'h0);
    // R13 disarmed inputs ignored
    drive_irq(32'h0001_0001, 3);
    rd(A_STAT, 32'h0, "R13 no capture while disarmed");
    drive_irq(32'h0, 2);
    // R12 direct status write when unlocked
    wr(A_STAT, 32'h50);
    rd(A_STAT, 32'h50, "R12 status write unlocked");
    // R8, R2, R4, R5, R6
    wr(A_SETEN, 32'h40);
    rd(A_EN, 32'h40, "R8 set-enable");
    rd(A_SETEN, 32'h0, "R2 set-enable reads zero");
    rd(A_ACK, 32'h0, "R2 acknowledge reads zero");
    rd(A_PEND | 5'h3, 32'h40, "R2 low address bits ignored / R4 pending");
    rd(A_VEC, 32'd6, "R5 vector single");
    chk_irq(1'b0, "R6 output gated off");
    wr(A_CTRL, 32'h1);
    chk_irq(1'b1, "R6 output on");
    wr(A_SETEN, 32'h10);
    rd(A_EN, 32'h50, "R8 set-enable ORs");
    rd(A_VEC, 32'd4, "R5 lowest wins");
    wr(A_PEND, 32'h0);
    wr(A_VEC, 32'h0);
    rd(A_PEND, 32'h50, "R4 pending read-only");
    // R9, R7
    wr(A_CLREN, 32'h10);
    rd(A_EN, 32'h40, "R9 clear-enable");
    wr(A_ACK, 32'h40);
    rd(A_STAT, 32'h10, "R7 acknowledge");
    rd(A_VEC, 32'hFFFF_FFFF, "R5 none pending");
    chk_irq(1'b0, "R6 nothing pending");
    // R12 lock
    wr(A_CTRL, 32'h3);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h10, "R12 status write locked");
    wr(A_ACK, 32'h10);
    rd(A_STAT, 32'h0, "R7 acknowledge while armed");
    // R10 level capture survives acknowledge
    drive_irq(32'h8, 2);
    rd(A_STAT, 32'h8, "R10 level capture");
    wr(A_ACK, 32'h8);
    rd(A_STAT, 32'h8, "R10 level survives acknowledge");
    drive_irq(32'h0, 1);
    wr(A_ACK, 32'h8);
    rd(A_STAT, 32'h0, "R10 cleared after drop");
    // R11 edge capture
    drive_irq(32'h0002_0000, 2);
    rd(A_STAT, 32'h0002_0000, "R11 edge capture");
    wr(A_ACK, 32'h0002_0000);
    rd(A_STAT, 32'h0, "R11 held edge not recaptured");
    drive_irq(32'h0, 2);
    drive_irq(32'h0002_0000, 2);
    rd(A_STAT, 32'h0002_0000, "R11 fresh edge captured");
    wr(A_ACK, 32'h0002_0000);
    drive_irq(32'h0, 1);
    // R5 top index
    wr(A_CTRL, 32'h1);
    wr(A_SETEN, 32'h8000_0000);
    wr(A_STAT, 32'h8000_0000);
    rd(A_VEC, 32'd31, "R5 top index");
    chk_irq(1'b1, "R6 top index raises output");
    wr(A_STAT, 32'h8000_0040);
    rd(A_VEC, 32'd6, "R5 lower index overrides");
    report();
  end
endmodule